// File: doc/BRIEF.md
# Masked Lane Barrier Unit

This block synchronizes the lanes of one 32-lane thread group. Each lane raises a one-cycle arrive strobe and presents the participation mask it was given. The block tracks one pending episode at a time. The first legal arrival in an empty barrier fixes the episode mask. Later arrivals join only if they present the identical value. Once every lane named by the mask has arrived, the block waits for the memory system to report that it is drained. It then frees all participants with a single release pulse and is ready for a new episode.

The controller is a three-state machine. In `ST_IDLE` no episode is open. A legal arrival takes it to `ST_GATHER`, or straight to `ST_DRAIN` when every named lane arrives in that same cycle. `ST_GATHER` collects further matching arrivals and moves to `ST_DRAIN` when the set is complete. `ST_DRAIN` holds the stalled lanes until `mem_drained_i` is seen high, then pulses the release and returns to `ST_IDLE`. Two sticky flags report misuse: an arrival whose own mask bit is clear, and an arrival whose mask disagrees with the open episode.

Top module: `lane_barrier`

## Requirements
- R1: Lane i presents its mask on `mask_i[i*32 +: 32]`, and bit j of that mask names lane j as a participant.
- R2: A lane that arrives legally with the episode mask has `stall_o` high from the cycle after its arrival. No release happens before every lane named in the mask has arrived with the identical mask.
- R3: A lane whose bit is clear in the open episode mask never has `stall_o` high.
- R4: With all participants arrived, `release_o` stays zero until `mem_drained_i` is sampled high at a clock edge. The release appears in the cycle after that edge.
- R5: All participants see `release_o` high in the same single cycle, and their `stall_o` drops in that cycle. An arrival presented during the release cycle opens a new episode.
- R6: An arrival from a lane whose own bit is clear in its mask sets `err_self_o` from the next cycle. That lane does not stall.
- R7: A legal arrival whose mask differs from the open episode mask sets `err_mismatch_o` from the next cycle. That lane does not stall, and the episode is unaffected. When an empty barrier sees legal arrivals with different masks in the same cycle, the lowest-numbered lane's mask wins.
- R8: A synchronous active-high `rst` clears pending arrivals, the release output and both error flags. Both error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arrive_i | input | 32 | Per-lane arrive strobe |
| mask_i | input | 1024 | Per-lane participation masks, 32 bits per lane |
| mem_drained_i | input | 1 | Memory system has no outstanding stores |
| stall_o | output | 32 | Lane is held at the barrier |
| release_o | output | 32 | One-cycle release pulse per lane |
| err_self_o | output | 1 | Sticky: arrival without own mask bit |
| err_mismatch_o | output | 1 | Sticky: arrival with a disagreeing mask |

## Verification
The assertions assume that each lane strobes `arrive_i` once per episode and does not arrive again while it is stalled. They also assume that `rst` is high at the first clock edge. The stimulus keeps to this: each lane arrives once per episode, in ascending lane order or all in one burst. The only repeat arrival is the lane that was turned away by a mismatch, and it was never stalled. Drain is held low for a varied number of cycles before it is raised, so that the gating of the release is exercised at several distances from the completion.

// File: rtl/lbar_pkg.sv
package lbar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_DRAIN  = 2'd2
    } lbar_state_t;
endpackage

// File: rtl/lbar_ref_pick.sv
// Chooses the mask that opens an episode: the lowest-numbered lane with a legal arrival.
module lbar_ref_pick #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0]       arrive,
    input  logic [LANES*LANES-1:0] mask_flat,
    output logic [LANES-1:0]       pick_mask,
    output logic                   pick_valid
);
    always_comb begin
        pick_mask  = '0;
        pick_valid = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (arrive[i] && mask_flat[i*LANES + i]) begin
                pick_mask  = mask_flat[i*LANES +: LANES];
                pick_valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lbar_classify.sv
// Sorts each lane's arrival into illegal, matching or mismatching.
module lbar_classify #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0]       arrive,
    input  logic [LANES*LANES-1:0] mask_flat,
    input  logic [LANES-1:0]       ref_mask,
    output logic [LANES-1:0]       hit,
    output logic [LANES-1:0]       miss,
    output logic [LANES-1:0]       bad_self
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic own_bit;
        logic same;
        assign own_bit     = mask_flat[g*LANES + g];
        assign same        = (mask_flat[g*LANES +: LANES] == ref_mask);
        assign bad_self[g] = arrive[g] & ~own_bit;
        assign hit[g]      = arrive[g] & own_bit & same;
        assign miss[g]     = arrive[g] & own_bit & ~same;
    end
endmodule

// File: rtl/lane_barrier.sv
module lane_barrier #(
    parameter int LANES = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES-1:0]       arrive_i,
    input  logic [LANES*LANES-1:0] mask_i,
    input  logic                   mem_drained_i,
    output logic [LANES-1:0]       stall_o,
    output logic [LANES-1:0]       release_o,
    output logic                   err_self_o,
    output logic                   err_mismatch_o
);
    import lbar_pkg::*;

    lbar_state_t      state_q, state_d;
    logic [LANES-1:0] epi_q, epi_d;
    logic [LANES-1:0] arr_q, arr_d;
    logic [LANES-1:0] rel_d, rel_q;
    logic             err_self_q, err_mis_q;

    logic [LANES-1:0] pick_mask;
    logic             pick_valid;
    logic [LANES-1:0] ref_mask;
    logic [LANES-1:0] hit, miss, bad_self;

    lbar_ref_pick #(.LANES(LANES)) u_pick (
        .arrive     (arrive_i),
        .mask_flat  (mask_i),
        .pick_mask  (pick_mask),
        .pick_valid (pick_valid)
    );

    assign ref_mask = (state_q == ST_IDLE) ? pick_mask : epi_q;

    lbar_classify #(.LANES(LANES)) u_cls (
        .arrive    (arrive_i),
        .mask_flat (mask_i),
        .ref_mask  (ref_mask),
        .hit       (hit),
        .miss      (miss),
        .bad_self  (bad_self)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        epi_d   = epi_q;
        arr_d   = arr_q;
        rel_d   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_valid) begin
                    epi_d   = ref_mask;
                    arr_d   = hit;
                    state_d = (hit == ref_mask) ? ST_DRAIN : ST_GATHER;
                end
            end
            ST_GATHER: begin
                arr_d = arr_q | hit;
                if (arr_d == epi_q) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (mem_drained_i) begin
                    rel_d   = epi_q;
                    arr_d   = '0;
                    epi_d   = '0;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                arr_d   = '0;
                epi_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            epi_q   <= '0;
            arr_q   <= '0;
        end else begin
            state_q <= state_d;
            epi_q   <= epi_d;
            arr_q   <= arr_d;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rel_q      <= '0;
            err_self_q <= 1'b0;
            err_mis_q  <= 1'b0;
        end else begin
            rel_q      <= rel_d;
            err_self_q <= err_self_q | (|bad_self);
            err_mis_q  <= err_mis_q | (|miss);
        end
    end

    assign stall_o        = arr_q;
    assign release_o      = rel_q;
    assign err_self_o     = err_self_q;
    assign err_mismatch_o = err_mis_q;
endmodule

// File: rtl/lane_barrier_chk.sv
module lane_barrier_chk #(
    parameter int LANES = 32
) (
    input logic                   clk,
    input logic                   rst,
    input logic [LANES-1:0]       arrive_i,
    input logic [LANES*LANES-1:0] mask_i,
    input logic                   mem_drained_i,
    input logic [LANES-1:0]       stall_o,
    input logic [LANES-1:0]       release_o,
    input logic                   err_self_o,
    input logic                   err_mismatch_o
);
    logic [LANES-1:0] own_clear;
    for (genvar g = 0; g < LANES; g++) begin : g_own
        assign own_clear[g] = arrive_i[g] & ~mask_i[g*LANES + g];

        a_r6_no_stall: assert property (@(posedge clk) disable iff (rst)
            (own_clear[g] && !stall_o[g]) |=> !stall_o[g]);
    end

    a_r5_release_together: assert property (@(posedge clk) disable iff (rst)
        (|release_o) |-> ($past(stall_o) == release_o));

    a_r5_stall_cleared: assert property (@(posedge clk) disable iff (rst)
        (|release_o) |-> (stall_o == '0));

    a_r4_release_needs_drain: assert property (@(posedge clk) disable iff (rst)
        (|release_o) |-> $past(mem_drained_i));

    a_r6_self_flag: assert property (@(posedge clk) disable iff (rst)
        (|own_clear) |=> err_self_o);

    a_r8_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_self_o || err_mismatch_o) |=>
            ((err_self_o >= $past(err_self_o)) && (err_mismatch_o >= $past(err_mismatch_o))));

    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (stall_o == '0 && release_o == '0 && !err_self_o && !err_mismatch_o));
endmodule

bind lane_barrier lane_barrier_chk #(.LANES(LANES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .arrive_i       (arrive_i),
    .mask_i         (mask_i),
    .mem_drained_i  (mem_drained_i),
    .stall_o        (stall_o),
    .release_o      (release_o),
    .err_self_o     (err_self_o),
    .err_mismatch_o (err_mismatch_o)
);

// File: tb/tb_lane_barrier.sv
module tb_lane_barrier;
    localparam int L = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst = 1'b1;
    logic [L-1:0]     arrive = '0;
    logic [L*L-1:0]   mflat = '0;
    logic             drained = 1'b0;
    logic [L-1:0]     stall_o, release_o;
    logic             err_self_o, err_mismatch_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    lane_barrier #(.LANES(L)) dut (
        .clk            (clk),
        .rst            (rst),
        .arrive_i       (arrive),
        .mask_i         (mflat),
        .mem_drained_i  (drained),
        .stall_o        (stall_o),
        .release_o      (release_o),
        .err_self_o     (err_self_o),
        .err_mismatch_o (err_mismatch_o)
    );

    task automatic chkv(string req, logic [L-1:0] act, logic [L-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(int lane, logic [L-1:0] m);
        arrive[lane] = 1'b1;
        mflat[lane*L +: L] = m;
    endtask

    task automatic clear_in();
        arrive = '0;
        mflat  = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chkv("R8 stall", stall_o, '0);
        chkv("R8 release", release_o, '0);
        chkv("R8 flags", {30'd0, err_self_o, err_mismatch_o}, '0);
    endtask

    // called at a negedge; returns at the negedge where the release was checked
    task automatic run_ep(logic [L-1:0] m, bit burst, int hold);
        logic [L-1:0] seen;
        seen = '0;
        if (burst) begin
            for (int i = 0; i < L; i++) if (m[i]) drive(i, m);
            @(negedge clk);
            clear_in();
            chkv("R2 burst stall", stall_o, m);
            chkv("R5 pulse ended", release_o, '0);
        end else begin
            for (int i = 0; i < L; i++) begin
                if (m[i]) begin
                    drive(i, m);
                    @(negedge clk);
                    clear_in();
                    seen[i] = 1'b1;
                    chkv("R3 stall only arrived lanes", stall_o, seen);
                    chkv("R2 no early release", release_o, '0);
                end
            end
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chkv("R4 held without drain", release_o, '0);
            chkv("R4 still stalled", stall_o, m);
        end
        drained = 1'b1;
        @(negedge clk);
        drained = 1'b0;
        chkv("R5 release all", release_o, m);
        chkv("R5 stall cleared", stall_o, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        do_reset();

        // R1 R2 R3 R4 R5: single-lane masks on every lane
        for (int k = 0; k < L; k++) run_ep(32'h1 << k, k[0], k % 3);
        @(negedge clk);
        chkv("R5 pulse one cycle", release_o, '0);

        run_ep(32'hFFFF_FFFF, 1'b0, 2);
        run_ep(32'h5555_5555, 1'b1, 1);
        run_ep(32'h8000_0001, 1'b0, 0);
        for (int k = 1; k <= 4; k++) run_ep((32'h9E37_79B1 * k) | 32'h1, k[0], k);

        // R5: an arrival during the release cycle opens the next episode
        run_ep(32'h10, 1'b1, 0);
        run_ep(32'h10, 1'b1, 0);
        chkv("R8 no flags after clean use", {30'd0, err_self_o, err_mismatch_o}, '0);

        // R6: lane 3 arrives with its own bit clear
        drive(3, 32'h1);
        @(negedge clk);
        clear_in();
        chkv("R6 err_self set", {31'd0, err_self_o}, 32'd1);
        chkv("R6 lane not stalled", stall_o, '0);
        @(negedge clk);
        chkv("R8 err_self sticky", {31'd0, err_self_o}, 32'd1);
        do_reset();

        // R7: mismatch while an episode is open
        drive(0, 32'h3);
        @(negedge clk);
        clear_in();
        chkv("R7 first lane stalled", stall_o, 32'h1);
        drive(1, 32'h6);
        @(negedge clk);
        clear_in();
        chkv("R7 mismatch flag", {31'd0, err_mismatch_o}, 32'd1);
        chkv("R7 mismatching lane not stalled", stall_o, 32'h1);
        drive(1, 32'h3);
        @(negedge clk);
        clear_in();
        chkv("R7 episode completes", stall_o, 32'h3);
        drained = 1'b1;
        @(negedge clk);
        drained = 1'b0;
        chkv("R7 release", release_o, 32'h3);
        do_reset();

        // R7: conflicting masks in one cycle, lowest lane wins
        drive(2, 32'h0C);
        drive(3, 32'h18);
        @(negedge clk);
        clear_in();
        chkv("R7 lowest lane wins", stall_o, 32'h4);
        chkv("R7 conflict flagged", {31'd0, err_mismatch_o}, 32'd1);
        drive(3, 32'h0C);
        @(negedge clk);
        clear_in();
        chkv("R2 set complete", stall_o, 32'h0C);
        drained = 1'b1;
        @(negedge clk);
        drained = 1'b0;
        chkv("R7 release", release_o, 32'h0C);

        // R8: reset in the middle of an episode
        drive(5, 32'h60);
        @(negedge clk);
        clear_in();
        chkv("R2 partial stall", stall_o, 32'h20);
        do_reset();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule